// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block chooses where each operand of a five-stage, 32-bit load/store pipeline comes from when an older instruction has not yet retired its result. For the two ALU operands in the execute stage, it compares the source register numbers with the destination numbers held further down the pipe. It then produces a two-bit select that picks one of three values: the register-file value, the result waiting after execute, or the result waiting in writeback.

Every register in the pipeline, the register file included, updates only on the rising clock edge. A register read in decode cannot see a value that writeback commits in the same cycle. The unit therefore also bypasses the two decode-stage read ports. When the writeback port is writing the register being read, the port returns the writeback data in place of the stale stored value. The unit is purely combinational. The pipeline registers, the ALU, the register storage and stall control sit around it. All of its pins are plain control and data pins with no handshake, because every value is consumed in the cycle it is presented.

Top module: `operand_fwd_unit`

## Requirements
- R1: An ALU operand select is 2'b00 (register-file value) when neither later stage qualifies to forward to it.
- R2: An ALU operand select is 2'b10 when the post-execute stage has its write flag set and its destination equals that operand's nonzero source register.
- R3: An ALU operand select is 2'b01 when the writeback stage has its write flag set, its destination equals that operand's nonzero source register, and the post-execute stage does not qualify.
- R4: When both later stages qualify for the same operand, the select is 2'b10, because the post-execute result is the younger one.
- R5: A stage whose write flag is clear never forwards, even when its destination number matches.
- R6: A source or read address of register 0 never forwards or bypasses; register 0 always reads zero.
- R7: A decode read port reports bypass (1) and returns the writeback data when the writeback enable is set and the writeback address equals its nonzero read address. Otherwise it reports 0 and returns the register-file data unchanged.
- R8: The two ALU operands, and the two decode read ports, are resolved independently of each other.
- R9: The select value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_i | input | 5 | First source register number of the instruction in execute |
| ex_rt_i | input | 5 | Second source register number of the instruction in execute |
| exm_wr_en_i | input | 1 | Post-execute stage will write a register |
| exm_dst_i | input | 5 | Post-execute stage destination register number |
| mwb_wr_en_i | input | 1 | Writeback stage will write a register |
| mwb_dst_i | input | 5 | Writeback stage destination register number |
| id_rs_i | input | 5 | Decode-stage first read address |
| id_rt_i | input | 5 | Decode-stage second read address |
| rf_rs_data_i | input | 32 | Stored value read at id_rs_i |
| rf_rt_data_i | input | 32 | Stored value read at id_rt_i |
| wb_en_i | input | 1 | Register-file write enable in this cycle |
| wb_addr_i | input | 5 | Register-file write address |
| wb_data_i | input | 32 | Register-file write data |
| fwd_a_sel_o | output | 2 | First ALU operand select (00 file, 10 post-execute, 01 writeback) |
| fwd_b_sel_o | output | 2 | Second ALU operand select, same encoding |
| id_rs_byp_o | output | 1 | First read port takes writeback data |
| id_rt_byp_o | output | 1 | Second read port takes writeback data |
| id_rs_data_o | output | 32 | First read port value after bypass |
| id_rt_data_o | output | 32 | Second read port value after bypass |

## Verification
The assertions assume that all inputs are known and stable once combinational settling ends. They also assume that the destination numbers arrive already chosen: the register-format or load target is selected upstream. The stimulus drives every input at a fixed point away from the clock edge. It sweeps register numbers 0 to 7 in every combination of the two write flags, then adds directed vectors at the top register number. In this way, the zero register, every single match, every double match and every matched-but-disabled case are covered.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // ALU operand source choice; the bit positions are decoded by the operand muxes
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MWB = 2'b01,
    SEL_EXM = 2'b10
  } opnd_sel_e;

  localparam int N_OPND  = 2;
  localparam int N_RDPRT = 2;
endpackage

// File: rtl/fwd_opnd_sel.sv
module fwd_opnd_sel #(
  parameter int AW = 5
) (
  input  logic [AW-1:0]     src_i,
  input  logic              exm_wr_i,
  input  logic [AW-1:0]     exm_dst_i,
  input  logic              mwb_wr_i,
  input  logic [AW-1:0]     mwb_dst_i,
  output fwd_pkg::opnd_sel_e sel_o
);
  import fwd_pkg::*;

  logic src_live;
  logic exm_hit;
  logic mwb_hit;

  always_comb begin
    src_live = |src_i;
    exm_hit  = exm_wr_i && src_live && (exm_dst_i == src_i);
    mwb_hit  = mwb_wr_i && src_live && (mwb_dst_i == src_i);
    if (exm_hit)      sel_o = SEL_EXM;
    else if (mwb_hit) sel_o = SEL_MWB;
    else              sel_o = SEL_RF;
  end

  always_comb begin
    // R6
    zero_src_chk: assert (|src_i || sel_o == SEL_RF)
      else $error("register 0 forwarded");
    // R5
    no_wr_chk: assert (exm_wr_i || mwb_wr_i || sel_o == SEL_RF)
      else $error("forward with no write flag");
    // R9
    sel_legal_chk: assert (sel_o != 2'b11)
      else $error("illegal select");
    // R4
    exm_prio_chk: assert (!(exm_wr_i && exm_dst_i == src_i && |src_i) || sel_o == SEL_EXM)
      else $error("younger result not preferred");
  end
endmodule

// File: rtl/fwd_rdport_byp.sv
module fwd_rdport_byp #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic [AW-1:0] rd_addr_i,
  input  logic [DW-1:0] rf_data_i,
  input  logic          wb_en_i,
  input  logic [AW-1:0] wb_addr_i,
  input  logic [DW-1:0] wb_data_i,
  output logic          byp_o,
  output logic [DW-1:0] data_o
);
  always_comb begin
    byp_o  = wb_en_i && (|rd_addr_i) && (wb_addr_i == rd_addr_i);
    data_o = byp_o ? wb_data_i : rf_data_i;
  end

  always_comb begin
    // R7
    id_data_chk: assert (!byp_o || data_o == wb_data_i)
      else $error("bypass without writeback data");
    // R6
    id_zero_chk: assert (|rd_addr_i || !byp_o)
      else $error("register 0 bypassed");
    // R7
    id_pass_chk: assert (byp_o || data_o == rf_data_i)
      else $error("stored data altered");
  end
endmodule

// File: rtl/operand_fwd_unit.sv
module operand_fwd_unit #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic [AW-1:0] ex_rs_i,
  input  logic [AW-1:0] ex_rt_i,
  input  logic          exm_wr_en_i,
  input  logic [AW-1:0] exm_dst_i,
  input  logic          mwb_wr_en_i,
  input  logic [AW-1:0] mwb_dst_i,
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic [DW-1:0] rf_rs_data_i,
  input  logic [DW-1:0] rf_rt_data_i,
  input  logic          wb_en_i,
  input  logic [AW-1:0] wb_addr_i,
  input  logic [DW-1:0] wb_data_i,
  output logic [1:0]    fwd_a_sel_o,
  output logic [1:0]    fwd_b_sel_o,
  output logic          id_rs_byp_o,
  output logic          id_rt_byp_o,
  output logic [DW-1:0] id_rs_data_o,
  output logic [DW-1:0] id_rt_data_o
);
  import fwd_pkg::*;

  logic [AW-1:0]      ex_src   [N_OPND];
  opnd_sel_e          opnd_sel [N_OPND];
  logic [AW-1:0]      rd_addr  [N_RDPRT];
  logic [DW-1:0]      rd_raw   [N_RDPRT];
  logic [DW-1:0]      rd_out   [N_RDPRT];
  logic               rd_byp   [N_RDPRT];

  assign ex_src[0]  = ex_rs_i;
  assign ex_src[1]  = ex_rt_i;
  assign rd_addr[0] = id_rs_i;
  assign rd_addr[1] = id_rt_i;
  assign rd_raw[0]  = rf_rs_data_i;
  assign rd_raw[1]  = rf_rt_data_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    fwd_opnd_sel #(.AW(AW)) u_sel (
      .src_i     (ex_src[g]),
      .exm_wr_i  (exm_wr_en_i),
      .exm_dst_i (exm_dst_i),
      .mwb_wr_i  (mwb_wr_en_i),
      .mwb_dst_i (mwb_dst_i),
      .sel_o     (opnd_sel[g])
    );
  end

  for (genvar g = 0; g < N_RDPRT; g++) begin : g_rdp
    fwd_rdport_byp #(.AW(AW), .DW(DW)) u_byp (
      .rd_addr_i (rd_addr[g]),
      .rf_data_i (rd_raw[g]),
      .wb_en_i   (wb_en_i),
      .wb_addr_i (wb_addr_i),
      .wb_data_i (wb_data_i),
      .byp_o     (rd_byp[g]),
      .data_o    (rd_out[g])
    );
  end

  assign fwd_a_sel_o  = opnd_sel[0];
  assign fwd_b_sel_o  = opnd_sel[1];
  assign id_rs_byp_o  = rd_byp[0];
  assign id_rt_byp_o  = rd_byp[1];
  assign id_rs_data_o = rd_out[0];
  assign id_rt_data_o = rd_out[1];

  always_comb begin
    // R8
    opnd_indep_chk: assert (ex_rs_i != ex_rt_i || fwd_a_sel_o == fwd_b_sel_o)
      else $error("same source resolved differently");
  end
endmodule

// File: tb/operand_fwd_unit_tb.sv
module operand_fwd_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] ex_rs, ex_rt, exm_dst, mwb_dst, id_rs, id_rt, wb_addr;
  logic          exm_wr, mwb_wr, wb_en;
  logic [DW-1:0] rf_rs, rf_rt, wb_data;
  logic [1:0]    sel_a, sel_b;
  logic          byp_rs, byp_rt;
  logic [DW-1:0] d_rs, d_rt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  operand_fwd_unit #(.AW(AW), .DW(DW)) dut_i (
    .ex_rs_i(ex_rs), .ex_rt_i(ex_rt),
    .exm_wr_en_i(exm_wr), .exm_dst_i(exm_dst),
    .mwb_wr_en_i(mwb_wr), .mwb_dst_i(mwb_dst),
    .id_rs_i(id_rs), .id_rt_i(id_rt),
    .rf_rs_data_i(rf_rs), .rf_rt_data_i(rf_rt),
    .wb_en_i(wb_en), .wb_addr_i(wb_addr), .wb_data_i(wb_data),
    .fwd_a_sel_o(sel_a), .fwd_b_sel_o(sel_b),
    .id_rs_byp_o(byp_rs), .id_rt_byp_o(byp_rt),
    .id_rs_data_o(d_rs), .id_rt_data_o(d_rt)
  );

  function automatic logic [1:0] exp_sel(input logic [AW-1:0] s, input logic ew,
                                         input logic [AW-1:0] ed, input logic mw,
                                         input logic [AW-1:0] md);
    if (s == 0) return 2'b00;
    if (ew && ed == s) return 2'b10;
    if (mw && md == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_tag(input logic [AW-1:0] s, input logic ew,
                                    input logic [AW-1:0] ed, input logic mw,
                                    input logic [AW-1:0] md);
    if (s == 0) return "R6";
    if (ew && ed == s && mw && md == s) return "R4";
    if (ew && ed == s) return "R2";
    if (mw && md == s) return "R3";
    if (ed == s || md == s) return "R5";
    return "R1";
  endfunction

  task automatic chk_sel(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp || act === 2'b11) begin
      errors++;
      $display("FAIL %s sel act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input logic [AW-1:0] ra, input logic [DW-1:0] rfd,
                        input logic act_b, input logic [DW-1:0] act_d);
    logic eb;
    logic [DW-1:0] ed;
    string tag;
    eb = wb_en && ra != 0 && wb_addr == ra;
    ed = eb ? wb_data : rfd;
    tag = (ra == 0) ? "R6" : "R7";
    checks++;
    if (act_b !== eb || act_d !== ed) begin
      errors++;
      $display("FAIL %s rdport act=%b/%h exp=%b/%h", tag, act_b, act_d, eb, ed);
    end
  endtask

  task automatic run_vec(input logic [AW-1:0] a, input logic [AW-1:0] b,
                         input logic ew, input logic [AW-1:0] ed,
                         input logic mw, input logic [AW-1:0] md,
                         input logic we, input logic [AW-1:0] wa);
    @(negedge clk);
    ex_rs = a; ex_rt = b; exm_wr = ew; exm_dst = ed; mwb_wr = mw; mwb_dst = md;
    id_rs = a; id_rt = b; wb_en = we; wb_addr = wa;
    wb_data = {8'hA5, 3'b0, a, 3'b0, ed, 3'b0, md};
    rf_rs = ~wb_data ^ 32'h1111_0000;
    rf_rt = wb_data ^ 32'h0F0F_0F0F;
    #1;
    // R8: each operand checked against its own source
    chk_sel(sel_tag(a, ew, ed, mw, md), sel_a, exp_sel(a, ew, ed, mw, md));
    chk_sel(sel_tag(b, ew, ed, mw, md), sel_b, exp_sel(b, ew, ed, mw, md));
    chk_rd(a, rf_rs, byp_rs, d_rs);
    chk_rd(b, rf_rt, byp_rt, d_rt);
  endtask

  initial begin
    ex_rs = 0; ex_rt = 0; exm_wr = 0; exm_dst = 0; mwb_wr = 0; mwb_dst = 0;
    id_rs = 0; id_rt = 0; wb_en = 0; wb_addr = 0; wb_data = 0; rf_rs = 0; rf_rt = 0;
    #1;
    // R1: idle inputs select the register file
    chk_sel("R1", sel_a, 2'b00);
    chk_sel("R1", sel_b, 2'b00);
    for (int s = 0; s < 8; s++)
      for (int e = 0; e < 8; e++)
        for (int m = 0; m < 8; m++)
          for (int f = 0; f < 4; f++)
            run_vec(AW'(s), AW'(7 - s), f[0], AW'(e), f[1], AW'(m), f[0] ^ f[1], AW'(m));
    // R2 R3 R4: top register number
    run_vec(5'd31, 5'd30, 1'b1, 5'd31, 1'b1, 5'd31, 1'b1, 5'd31);
    run_vec(5'd31, 5'd30, 1'b0, 5'd31, 1'b1, 5'd30, 1'b1, 5'd30);
    run_vec(5'd30, 5'd31, 1'b1, 5'd31, 1'b0, 5'd30, 1'b0, 5'd31);
    // R6: register 0 with every enable set
    run_vec(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule